// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a write-through cache and the lower-level memory. Processor stores go into a small queue of block-sized entries, so the processor does not wait for memory. A store to a block that already has an open entry is folded into that entry. Each entry keeps its own byte-valid mask, and entries leave for memory as single block-wide writes, oldest first.

Every read the cache sends toward memory is first checked against the queue. If exactly one entry overlaps the requested word and that entry holds all of the word's bytes, the word is returned from the buffer. If no entry overlaps the word, the read may use the memory port at once. While such a read is present, no new block write is started. A partial overlap, or an overlap with more than one entry, blocks the read until the drains remove the conflict.

The drain sequencer is a three-state machine. DR_IDLE means no request is out. From DR_IDLE it goes to DR_SEND when entries are pending and no memory read is claiming the port, and to DR_YIELD when entries are pending but a read is claiming the port. DR_YIELD means writes are waiting behind a read; it goes to DR_SEND once the claim ends. DR_SEND holds the write request until the acknowledge arrives, then returns to DR_IDLE.

Top module: `merge_write_buffer`

## Requirements
- R1: After reset the buffer is empty. `st_ready` is 1, `mem_wr_req` is 0, and any valid read reports `rd_clear`=1.
- R2: A store accepted while the buffer is not full raises `st_ready` in the same cycle. Its data appears in a later block write.
- R3: A store to a block held in an entry that is not being drained is merged into that entry. Bytes enabled by `st_be` (bit k = byte k of the word) overwrite the old bytes and set their mask bits. The line mask uses bit 4*w+k for byte k of word w.
- R4: When every entry is occupied, `st_ready` is 0 for a store that cannot merge. It stays 1 for a store that can merge.
- R5: A read word is selected by address bits [3:2], and bits [1:0] are ignored. If exactly one entry overlaps the word and its mask covers all four bytes, `rd_fwd`=1 and `rd_data` is that word.
- R6: If an entry partly covers the read word, or more than one entry overlaps it, both `rd_fwd` and `rd_clear` are 0.
- R7: If no entry has a mask bit in the read word, `rd_clear`=1.
- R8: While a read with `rd_clear`=1 is present and no request is out, `mem_wr_req` stays 0. The write starts in the cycle after the read goes away.
- R9: A block write presents the block address (byte address bits [15:4]), the full 128-bit line with word w at bits [32w+31:32w], and the 16-bit byte mask. These hold stable with `mem_wr_req` until `mem_wr_ack`. The entry is freed on the acknowledge.
- R10: Entries are written to memory in the order they were allocated.
- R11: A store to the block being drained takes a new entry and does not alter the drain in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_addr | input | 16 | Store byte address |
| st_data | input | 32 | Store word |
| st_be | input | 4 | Store byte enables |
| st_ready | output | 1 | Store accepted this cycle |
| rd_valid | input | 1 | Read check request |
| rd_addr | input | 16 | Read byte address |
| rd_fwd | output | 1 | Read satisfied from buffer |
| rd_data | output | 32 | Forwarded word |
| rd_clear | output | 1 | No overlap, read may use memory |
| mem_wr_req | output | 1 | Block write request |
| mem_wr_addr | output | 12 | Block address |
| mem_wr_data | output | 128 | Block line |
| mem_wr_mask | output | 16 | Byte mask of the line |
| mem_wr_ack | input | 1 | Block write taken |

## Verification
The hardest state to reach is two entries for the same block at once. This happens only when a store arrives while the older entry for that block is already being drained. The bench withholds the acknowledge so the first entry stays in DR_SEND. It then stores to that block again, which yields a double overlap for reads and a later second write for the same block. The same withheld acknowledge lets the queue fill completely, so the stall and merge-while-full cases can be seen. A held read is used to drive the sequencer into DR_YIELD.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

    typedef enum logic [1:0] {
        DR_IDLE  = 2'd0,
        DR_YIELD = 2'd1,
        DR_SEND  = 2'd2
    } drain_state_e;

endpackage

// File: rtl/mwb_drain_fsm.sv
module mwb_drain_fsm
    import mwb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic rd_claim,
    input  logic mem_wr_ack,
    output logic mem_wr_req,
    output logic pop,
    output logic head_busy
);

    drain_state_e cur, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= DR_IDLE;
        else        cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        unique case (cur)
            DR_IDLE:  if (pending) nxt = rd_claim ? DR_YIELD : DR_SEND;
            DR_YIELD: if (!rd_claim) nxt = DR_SEND;
            DR_SEND:  if (mem_wr_ack) nxt = DR_IDLE;
            default:  nxt = DR_IDLE;
        endcase
    end

    always_comb begin
        mem_wr_req = (cur == DR_SEND);
        head_busy  = (cur == DR_SEND);
        pop        = (cur == DR_SEND) && mem_wr_ack;
    end

    // R8: a memory read claiming the port blocks the start of a write
    a_r8_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_claim && !mem_wr_req) |=> !mem_wr_req);

    // R9: the request is held until it is acknowledged
    a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> mem_wr_req);

    // R9: an entry is freed only when one is pending
    a_r9_pop_pending: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> pending);

endmodule

// File: rtl/mwb_entries.sv
module mwb_entries #(
    parameter int DEPTH  = 4,
    parameter int TAG_W  = 12,
    parameter int LINE_W = 128,
    localparam int MASK_W = LINE_W / 8,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [MASK_W-1:0] wr_mask,
    input  logic              pop,
    input  logic              head_busy,
    output logic              merge_hit,
    output logic              full,
    output logic              pending,
    output logic [TAG_W-1:0]  head_tag,
    output logic [LINE_W-1:0] head_line,
    output logic [MASK_W-1:0] head_mask,
    output logic [DEPTH-1:0]  slot_vld,
    output logic [TAG_W-1:0]  slot_tag  [DEPTH],
    output logic [LINE_W-1:0] slot_line [DEPTH],
    output logic [MASK_W-1:0] slot_mask [DEPTH]
);

    logic [DEPTH-1:0]  vld_q;
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [LINE_W-1:0] line_q [DEPTH];
    logic [MASK_W-1:0] mask_q [DEPTH];
    logic [PTR_W-1:0]  head;
    logic [PTR_W:0]    cnt;
    logic [PTR_W-1:0]  tail;
    logic [DEPTH-1:0]  match;
    logic [LINE_W-1:0] wr_bits;
    logic              alloc;

    for (genvar b = 0; b < MASK_W; b++) begin : g_bexp
        assign wr_bits[b*8 +: 8] = {8{wr_mask[b]}};
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_match
        assign match[i] = vld_q[i] && (tag_q[i] == wr_tag)
                          && !(head_busy && (head == PTR_W'(i)));
    end

    assign merge_hit = |match;
    assign full      = (cnt == (PTR_W+1)'(DEPTH));
    assign pending   = (cnt != '0);
    assign tail      = head + cnt[PTR_W-1:0];
    assign alloc     = wr_en && !merge_hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic take, fold, drop;
        assign take = alloc && (tail == PTR_W'(i));
        assign fold = wr_en && match[i];
        assign drop = pop && (head == PTR_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n)    vld_q[i] <= 1'b0;
            else if (take) vld_q[i] <= 1'b1;
            else if (drop) vld_q[i] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (take) begin
                tag_q[i]  <= wr_tag;
                line_q[i] <= wr_line & wr_bits;
                mask_q[i] <= wr_mask;
            end else if (fold) begin
                line_q[i] <= (line_q[i] & ~wr_bits) | (wr_line & wr_bits);
                mask_q[i] <= mask_q[i] | wr_mask;
            end
        end

        assign slot_tag[i]  = tag_q[i];
        assign slot_line[i] = line_q[i];
        assign slot_mask[i] = mask_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            cnt  <= '0;
        end else begin
            if (pop) head <= head + 1'b1;
            cnt <= cnt + (PTR_W+1)'(alloc) - (PTR_W+1)'(pop);
        end
    end

    assign slot_vld  = vld_q;
    assign head_tag  = tag_q[head];
    assign head_line = line_q[head];
    assign head_mask = mask_q[head];

    // R4: occupancy never exceeds the entry count
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (PTR_W+1)'(DEPTH));

    // R3: a block has at most one open entry that can take merges
    a_r3_single_home: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match) <= 1);

    // R9: an acknowledge with no allocation lowers the occupancy by one
    a_r9_free_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !alloc) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/mwb_read_check.sv
module mwb_read_check #(
    parameter int DEPTH  = 4,
    parameter int TAG_W  = 12,
    parameter int LINE_W = 128,
    parameter int WORD_W = 32,
    localparam int MASK_W = LINE_W / 8,
    localparam int WB     = WORD_W / 8,
    localparam int WSEL_W = $clog2(LINE_W / WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [WSEL_W-1:0] rd_wsel,
    input  logic [DEPTH-1:0]  slot_vld,
    input  logic [TAG_W-1:0]  slot_tag  [DEPTH],
    input  logic [LINE_W-1:0] slot_line [DEPTH],
    input  logic [MASK_W-1:0] slot_mask [DEPTH],
    output logic              rd_fwd,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_clear
);

    logic [DEPTH-1:0]  ov, cov;
    logic [WORD_W-1:0] word [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic [WB-1:0] wm;
        assign wm      = slot_mask[i][rd_wsel*WB +: WB];
        assign word[i] = slot_line[i][rd_wsel*WORD_W +: WORD_W];
        assign ov[i]   = slot_vld[i] && (slot_tag[i] == rd_tag) && (|wm);
        assign cov[i]  = ov[i] && (&wm);
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++)
            if (cov[i]) rd_data = rd_data | word[i];
    end

    assign rd_fwd   = rd_valid && (ov != '0) && ((ov & (ov - 1'b1)) == '0)
                      && (cov == ov);
    assign rd_clear = rd_valid && (ov == '0);

    // R5: a forwarded read never also goes to memory
    a_r5_fwd_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_fwd && rd_clear));

    // R6: forwarding only with a single fully covering entry
    a_r6_single_src: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fwd |-> ($onehot(cov) && (cov == ov)));

endmodule

// File: rtl/merge_write_buffer.sv
module merge_write_buffer #(
    parameter int ADDR_W    = 16,
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 4,
    parameter int DEPTH     = 4,
    localparam int WB       = WORD_W / 8,
    localparam int LINE_W   = WORD_W * BLK_WORDS,
    localparam int MASK_W   = LINE_W / 8,
    localparam int BSEL_W   = $clog2(WB),
    localparam int WSEL_W   = $clog2(BLK_WORDS),
    localparam int OFF_W    = BSEL_W + WSEL_W,
    localparam int TAG_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [WORD_W-1:0] st_data,
    input  logic [WB-1:0]     st_be,
    output logic              st_ready,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_fwd,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_clear,
    output logic              mem_wr_req,
    output logic [TAG_W-1:0]  mem_wr_addr,
    output logic [LINE_W-1:0] mem_wr_data,
    output logic [MASK_W-1:0] mem_wr_mask,
    input  logic              mem_wr_ack
);

    logic [TAG_W-1:0]  st_tag;
    logic [WSEL_W-1:0] st_wsel;
    logic [LINE_W-1:0] st_line;
    logic [MASK_W-1:0] st_lmask;
    logic              st_fire, merge_hit, full, pending, pop, head_busy;
    logic [DEPTH-1:0]  s_vld;
    logic [TAG_W-1:0]  s_tag  [DEPTH];
    logic [LINE_W-1:0] s_line [DEPTH];
    logic [MASK_W-1:0] s_mask [DEPTH];

    assign st_tag   = st_addr[ADDR_W-1:OFF_W];
    assign st_wsel  = st_addr[OFF_W-1:BSEL_W];
    assign st_line  = LINE_W'(st_data) << (st_wsel * WORD_W);
    assign st_lmask = MASK_W'(st_be) << (st_wsel * WB);
    assign st_ready = merge_hit || !full;
    assign st_fire  = st_valid && st_ready;

    mwb_entries #(.DEPTH(DEPTH), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_entries (
        .clk(clk), .rst_n(rst_n),
        .wr_en(st_fire), .wr_tag(st_tag), .wr_line(st_line), .wr_mask(st_lmask),
        .pop(pop), .head_busy(head_busy),
        .merge_hit(merge_hit), .full(full), .pending(pending),
        .head_tag(mem_wr_addr), .head_line(mem_wr_data), .head_mask(mem_wr_mask),
        .slot_vld(s_vld), .slot_tag(s_tag), .slot_line(s_line), .slot_mask(s_mask)
    );

    mwb_read_check #(.DEPTH(DEPTH), .TAG_W(TAG_W), .LINE_W(LINE_W),
                     .WORD_W(WORD_W)) u_rdchk (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_tag(rd_addr[ADDR_W-1:OFF_W]),
        .rd_wsel(rd_addr[OFF_W-1:BSEL_W]),
        .slot_vld(s_vld), .slot_tag(s_tag), .slot_line(s_line), .slot_mask(s_mask),
        .rd_fwd(rd_fwd), .rd_data(rd_data), .rd_clear(rd_clear)
    );

    mwb_drain_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .pending(pending), .rd_claim(rd_clear), .mem_wr_ack(mem_wr_ack),
        .mem_wr_req(mem_wr_req), .pop(pop), .head_busy(head_busy)
    );

    // R9 and R11: the presented block stays stable until acknowledged
    a_r9_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=>
            ($stable(mem_wr_addr) && $stable(mem_wr_data) && $stable(mem_wr_mask)));

    // R2: a request is only raised with pending entries
    a_r2_req_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> pending);

endmodule

// File: tb/tb_merge_write_buffer.sv
module tb_merge_write_buffer;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0;
    logic [15:0]  st_addr = '0;
    logic [31:0]  st_data = '0;
    logic [3:0]   st_be = '0;
    logic         st_ready;
    logic         rd_valid = 1'b0;
    logic [15:0]  rd_addr = '0;
    logic         rd_fwd, rd_clear;
    logic [31:0]  rd_data;
    logic         mem_wr_req;
    logic [11:0]  mem_wr_addr;
    logic [127:0] mem_wr_data;
    logic [15:0]  mem_wr_mask;
    logic         mem_wr_ack = 1'b0;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    merge_write_buffer dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_ready(st_ready),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_fwd(rd_fwd), .rd_data(rd_data),
        .rd_clear(rd_clear),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_mask(mem_wr_mask), .mem_wr_ack(mem_wr_ack)
    );

    // read table: address, expect forward, expect clear, expect data
    localparam int NRD = 7;
    localparam logic [15:0] RV_ADDR [NRD] =
        '{16'h0204, 16'h0208, 16'h020C, 16'h0100, 16'h0300, 16'h0104, 16'h0206};
    localparam logic RV_FWD [NRD] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam logic RV_CLR [NRD] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [31:0] RV_DATA [NRD] =
        '{32'hBBBB0002, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'hBBBB0002};

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic store(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be,
                         input logic exp_rdy, input string req);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
        #1 chk(req, 128'(st_ready), 128'(exp_rdy));
        @(posedge clk);
        #1 st_valid = 1'b0;
    endtask

    task automatic drain(input logic [11:0] tag, input logic [127:0] line,
                         input logic [15:0] mask, input string req);
        int w;
        w = 0;
        @(negedge clk);
        while (!mem_wr_req && w < 20) begin
            @(negedge clk);
            w++;
        end
        chk({req, " req"}, 128'(mem_wr_req), 128'(1));
        chk({req, " addr"}, 128'(mem_wr_addr), 128'(tag));
        chk({req, " data"}, mem_wr_data, line);
        chk({req, " mask"}, 128'(mem_wr_mask), 128'(mask));
        mem_wr_ack = 1'b1;
        @(posedge clk);
        #1 mem_wr_ack = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = 16'h0100;
        #1;
        chk("R1 st_ready", 128'(st_ready), 128'(1));
        chk("R1 mem_wr_req", 128'(mem_wr_req), 128'(0));
        chk("R1 rd_clear", 128'(rd_clear), 128'(1));
        rd_valid = 1'b0;

        // preload with acknowledge withheld; first entry enters drain at once
        store(16'h0100, 32'hAAAA0001, 4'hF, 1'b1, "R2 store A");
        store(16'h0204, 32'hBBBB0002, 4'hF, 1'b1, "R2 store B");
        store(16'h0208, 32'h0000CC03, 4'h3, 1'b1, "R3 merge B");
        store(16'h0100, 32'hDDDD0004, 4'hF, 1'b1, "R11 store to draining block");

        // read table walk (R5, R6, R7)
        for (int k = 0; k < NRD; k++) begin
            string tag;
            tag = RV_FWD[k] ? "R5" : (RV_CLR[k] ? "R7" : "R6");
            @(negedge clk);
            rd_valid = 1'b1; rd_addr = RV_ADDR[k];
            #1;
            chk({tag, " fwd"}, 128'(rd_fwd), 128'(RV_FWD[k]));
            chk({tag, " clear"}, 128'(rd_clear), 128'(RV_CLR[k]));
            if (RV_FWD[k]) chk({tag, " data"}, 128'(rd_data), 128'(RV_DATA[k]));
            rd_valid = 1'b0;
        end

        // R4: fill the last entry, then stall a new block, then merge while full
        store(16'h0400, 32'h55550005, 4'hF, 1'b1, "R4 last entry");
        store(16'h0500, 32'h99990009, 4'hF, 1'b0, "R4 stall when full");
        store(16'h0208, 32'h77660000, 4'hC, 1'b1, "R4 merge when full");

        // R9: request held without acknowledge
        repeat (5) @(negedge clk);
        #1;
        chk("R9 held req", 128'(mem_wr_req), 128'(1));
        chk("R9 held addr", 128'(mem_wr_addr), 128'(12'h010));

        // drains in allocation order (R10), draining entry untouched (R11)
        drain(12'h010, {96'h0, 32'hAAAA0001}, 16'h000F, "R11 first drain");
        drain(12'h020, {32'h0, 32'h7766CC03, 32'hBBBB0002, 32'h0}, 16'h0FF0, "R3 merged drain");
        drain(12'h010, {96'h0, 32'hDDDD0004}, 16'h000F, "R10 second block copy");
        drain(12'h040, {96'h0, 32'h55550005}, 16'h000F, "R10 last drain");
        repeat (3) @(negedge clk);
        #1 chk("R9 empty after acks", 128'(mem_wr_req), 128'(0));

        // R8: a memory read holds off the next write
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = 16'h0900;
        store(16'h0600, 32'h66660006, 4'hF, 1'b1, "R2 store under read");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            #1 chk("R8 write held off", 128'(mem_wr_req), 128'(0));
        end
        rd_valid = 1'b0;
        @(negedge clk);
        #1 chk("R8 write starts", 128'(mem_wr_req), 128'(1));
        drain(12'h060, {96'h0, 32'h66660006}, 16'h000F, "R9 after read");

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule